// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the device side of a word-wide parallel NOR flash command interface, wrapped around a small parameterized storage array. It watches write cycles on a simple synchronous bus and picks out the unlock sequences that start a sector erase or a single-word program. Any other write is treated as a stray access and clears the partial sequence.

Once a sequence completes, the block stays busy for a fixed number of clock cycles. During that window it applies the operation to the array. An erase turns every bit of one sector back to one. A program can only pull bits from one to zero.

While the block is busy, a read returns a status word instead of array data. Polling software can therefore see progress through a toggling bit and a bit that is the complement of the last data bit it wrote. When the block is idle, reads return the addressed array word one cycle after the read strobe.

Top module: `flash_cmd_dev`

## Requirements
- R1: After reset, `busy` is low, `rdata` is zero and the sequence tracker is idle.
- R2: The write series 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@X starts an erase. `busy` then rises on the cycle after the last write and stays high for exactly ERASE_CYC cycles. When ERASE_CYC is below the sector size, the erase lasts one cycle per sector word instead.
- R3: The erased sector is the one that holds address X, taken from the top SECT_W bits of `addr`. Every word of that sector reads 0xFFFF afterwards. Words in other sectors keep their values.
- R4: The write series 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, D@T starts a program. `busy` stays high for exactly PROG_CYC cycles, and the word at T then holds its old value ANDed with D.
- R5: Command values are compared on `wdata[7:0]` and command addresses on the full `addr`. A write that does not fit the next step returns the tracker to idle and starts nothing. A correct sequence that follows is then accepted.
- R6: A write whose `wdata[7:0]` is 0xF0, at any step and while not busy, returns the tracker to idle. This includes the data step of a program.
- R7: A read issued while busy returns bit 7 equal to the inverse of bit 7 of the final sequence write. Bit 6 is 0 on the first read after the operation starts and inverts on every later read. All other bits are zero.
- R8: Writes received while busy are ignored. They neither change the array nor stretch or abort the busy period.
- R9: A read issued while idle returns the array word at `addr` on `rdata` one clock after `re` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe, one cycle per bus write |
| re | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Array word when idle, status word when busy |
| busy | output | 1 | High while an erase or program is in progress |

## Verification
The assertions assume that every `we` and `re` pulse lasts a single cycle, and that `we` and `re` are never high in the same cycle. They also assume that a new busy period cannot begin immediately after the previous one, because at least four writes are needed to start one. The bench drives each strobe for exactly one cycle, leaves idle cycles between accesses and never mixes reads and writes. It reads only words inside sectors it has already erased, so every expected value is defined.

// File: rtl/flash_cmd_dev.sv
`timescale 1ns/1ps
module flash_cmd_dev #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 3,
  parameter int ERASE_CYC = 300,
  parameter int PROG_CYC  = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int OFF_W      = ADDR_W - SECT_W;
  localparam int SECT_WORDS = 1 << OFF_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int ER_LEN     = (ERASE_CYC > SECT_WORDS) ? ERASE_CYC : SECT_WORDS;
  localparam int MAX_LEN    = (ER_LEN > PROG_CYC) ? ER_LEN : PROG_CYC;
  localparam int T_W        = $clog2(MAX_LEN + 1);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(12'h2AA);

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_E1, S_E2, S_E3, S_PGM, S_BUSY_E, S_BUSY_P
  } st_t;

  st_t               st;
  logic [T_W-1:0]    tmr;
  logic [SECT_W-1:0] sect;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pdata;
  logic              fbit, tog;
  logic [DATA_W-1:0] mem [DEPTH];

  wire [7:0]     cb    = wdata[7:0];
  wire           at_hi = addr == A_HI;
  wire           at_lo = addr == A_LO;
  wire [T_W-1:0] last  = (st == S_BUSY_E) ? T_W'(ER_LEN - 1) : T_W'(PROG_CYC - 1);
  wire           erase_wr = (st == S_BUSY_E) && (tmr < T_W'(SECT_WORDS));
  wire           prog_wr  = (st == S_BUSY_P) && (tmr == T_W'(PROG_CYC - 1));
  wire [DATA_W-1:0] status = DATA_W'({fbit, tog, 6'b0});

  assign busy = (st == S_BUSY_E) || (st == S_BUSY_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; sect <= '0; paddr <= '0;
      pdata <= '0; fbit <= 1'b0; tog <= 1'b0;
    end else if (busy) begin
      if (re) tog <= ~tog;
      if (tmr == last) begin st <= S_IDLE; tmr <= '0; end
      else tmr <= tmr + 1'b1;
    end else if (we) begin
      if (cb == 8'hF0) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE: st <= (at_hi && cb == 8'hAA) ? S_U1 : S_IDLE;
          S_U1:   st <= (at_lo && cb == 8'h55) ? S_U2 : S_IDLE;
          S_U2:   st <= (at_hi && cb == 8'hA0) ? S_PGM :
                        (at_hi && cb == 8'h80) ? S_E1 : S_IDLE;
          S_E1:   st <= (at_hi && cb == 8'hAA) ? S_E2 : S_IDLE;
          S_E2:   st <= (at_lo && cb == 8'h55) ? S_E3 : S_IDLE;
          S_E3:
            if (cb == 8'h30) begin
              st <= S_BUSY_E; sect <= addr[ADDR_W-1:OFF_W];
              fbit <= ~wdata[7]; tog <= 1'b0; tmr <= '0;
            end else st <= S_IDLE;
          S_PGM: begin
            st <= S_BUSY_P; paddr <= addr; pdata <= wdata;
            fbit <= ~wdata[7]; tog <= 1'b0; tmr <= '0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (erase_wr)     mem[{sect, tmr[OFF_W-1:0]}] <= '1;
    else if (prog_wr) mem[paddr] <= mem[paddr] & pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= busy ? status : mem[addr];
  end

  logic [T_W-1:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  assert_busy_len_R2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (($past(st) == S_BUSY_E) ? ($past(run) == T_W'(ER_LEN - 1))
                                              : ($past(run) == T_W'(PROG_CYC - 1))));

  assert_start_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we));

  assert_status_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && re) |=> (rdata[DATA_W-1:8] == '0 && rdata[5:0] == 6'b0 && rdata[7] == $past(fbit)));

  assert_status_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && re && $past(busy && re)) |=> (rdata[6] != $past(rdata[6])));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(st) != st) |-> 1'b0);
endmodule

// File: tb/flash_cmd_dev_tb.sv
`timescale 1ns/1ps
module flash_cmd_dev_tb;
  localparam int AW = 11, DW = 16, SW = 3, EC = 300, PC = 12;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic busy;

  flash_cmd_dev #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .ERASE_CYC(EC), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy));

  always #2 clk = ~clk;

  int total = 0, bad = 0, run = 0, last_run = 0;
  bit done = 0;
  logic [DW-1:0] q_exp[$];
  string q_tag[$];
  logic pend = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= re;
  always @(negedge clk) begin
    if (pend) begin
      if (q_exp.size() == 0) chk("scoreboard", rdata, 'x);
      else chk(q_tag.pop_front(), rdata, q_exp.pop_front());
    end
  end

  always @(negedge clk) begin
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); re = 1'b1; addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic erase(input logic [AW-1:0] a);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, 16'h0030);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {15'b0, busy}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {15'b0, busy}, 16'h0);
    chk("R1 rdata after reset", rdata, 16'h0);

    erase(11'h200);
    chk("R2 busy after erase seq", {15'b0, busy}, 16'h1);
    rd(11'h000, 16'h0080, "R7 erase status first");
    rd(11'h000, 16'h00C0, "R7 erase status second");
    rd(11'h000, 16'h0080, "R7 erase status third");
    wait_idle();
    chk("R2 erase busy length", DW'(last_run), DW'(EC));
    rd(11'h200, 16'hFFFF, "R3 sector2 first word");
    rd(11'h2FF, 16'hFFFF, "R3 sector2 last word");

    prog(11'h200, 16'hABCD);
    chk("R4 busy after program seq", {15'b0, busy}, 16'h1);
    rd(11'h000, 16'h0000, "R7 program status first");
    rd(11'h000, 16'h0040, "R7 program status second");
    wait_idle();
    chk("R4 program busy length", DW'(last_run), DW'(PC));
    rd(11'h200, 16'hABCD, "R9 read programmed word");

    erase(11'h1A3);
    wait_idle();
    rd(11'h100, 16'hFFFF, "R3 sector1 first word");
    rd(11'h1FF, 16'hFFFF, "R3 sector1 last word");
    rd(11'h200, 16'hABCD, "R3 other sector kept");

    prog(11'h1A3, 16'h1234); wait_idle();
    rd(11'h1A3, 16'h1234, "R4 program on erased");
    prog(11'h1A3, 16'hFF0F); wait_idle();
    rd(11'h1A3, 16'h1204, "R4 program ANDs");
    prog(11'h1A3, 16'hFFFF); wait_idle();
    rd(11'h1A3, 16'h1204, "R4 ones do not set bits");

    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A1); wr(11'h101, 16'h0000);
    @(negedge clk);
    chk("R5 wrong value no busy", {15'b0, busy}, 16'h0);
    rd(11'h101, 16'hFFFF, "R5 wrong value no write");
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0); wr(11'h102, 16'h0000);
    @(negedge clk);
    chk("R5 wrong address no busy", {15'b0, busy}, 16'h0);
    rd(11'h102, 16'hFFFF, "R5 wrong address no write");
    prog(11'h103, 16'h00C5);
    rd(11'h000, 16'h0000, "R7 status bit7 high data");
    rd(11'h000, 16'h0040, "R7 status bit7 high data second");
    wait_idle();
    rd(11'h103, 16'h00C5, "R5 recovery after mismatch");

    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'h555, 16'h00F0);
    wr(11'h104, 16'h0000);
    @(negedge clk);
    chk("R6 abort before data no busy", {15'b0, busy}, 16'h0);
    rd(11'h104, 16'hFFFF, "R6 abort before data");
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080); wr(11'h123, 16'h00F0);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h200, 16'h0030);
    @(negedge clk);
    chk("R6 abort mid erase no busy", {15'b0, busy}, 16'h0);
    rd(11'h200, 16'hABCD, "R6 abort mid erase");

    erase(11'h1A3);
    prog(11'h200, 16'h0000);
    wr(11'h555, 16'h00F0);
    chk("R8 busy kept during writes", {15'b0, busy}, 16'h1);
    wait_idle();
    chk("R8 erase length unchanged", DW'(last_run), DW'(EC));
    rd(11'h200, 16'hABCD, "R8 program while busy ignored");
    rd(11'h1A3, 16'hFFFF, "R3 reerase sector1");
    chk("R8 no late start", {15'b0, busy}, 16'h0);

    prog(11'h1A3, 16'h0F0F);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    chk("R8 busy during program", {15'b0, busy}, 16'h1);
    wait_idle();
    chk("R8 program length unchanged", DW'(last_run), DW'(PC));
    rd(11'h1A3, 16'h0F0F, "R8 program result");
    rd(11'h100, 16'hFFFF, "R8 no erase from busy writes");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule